// File: doc/BRIEF.md
# Falling-Edge / Low-Level External Interrupt Latch

This block turns one active-low external interrupt pin into a request line for the CPU. The pin is first brought into the clock domain. A falling transition then sets a pending latch. A small control register selects the sensitivity:

- **Edge only.** The latch holds the request until an acknowledge arrives.
- **Edge plus low level.** The request also holds for as long as the pin stays low.

The CPU acknowledges a request through its vector-fetch strobe. Software acknowledges the same way by writing a one to a self-clearing bit of the register. A mask bit in the register stops the request from reaching the CPU, but the pending state stays visible in a read-only status bit.

The control register is eight bits wide, with this layout:

- bit 0: sensitivity select, read/write (0 = edge only, 1 = edge plus low level)
- bit 1: request mask, read/write (1 = masked)
- bit 2: acknowledge, write-only, always reads 0
- bit 3: pending status, read-only
- bits 7:4: read as 0

Top module: `ext_irq_latch`

## Requirements
- R1: The pin is driven low before rising edge k, with the pin previously high. Status bit 3 and `cpu_irq_req` (when unmasked) are still 0 after edge k+1 and become 1 after edge k+2.
- R2: With bit 0 = 0, an acknowledge (vector fetch or software write) clears the status on the edge that samples it. The status then stays 0 while the pin remains low.
- R3: With bit 0 = 1, the status stays 1 while the synchronized pin is low, even after an acknowledge. It returns to 0 only once both an acknowledge has happened and the pin is high, in either order.
- R4: Writing a 1 to bit 2 acts exactly like a vector-fetch acknowledge. Bit 2 always reads 0.
- R5: An acknowledge does not block later activity. A falling edge after the acknowledge sets the status again.
- R6: When a falling edge and an acknowledge are sampled on the same clock edge, the latch stays set.
- R7: When bit 1 = 1, `cpu_irq_req` is 0 while status bit 3 still shows the pending state. Clearing bit 1 releases the request on the next edge.
- R8: A synchronous reset clears the pending latch, bit 0 and bit 1. A pin held low through a reset of at least three cycles produces no request after the reset.
- R9: A write updates bits 0 and 1 on the write edge. The read data is {4'b0, status, 1'b0, mask, mode}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_pin_n | input | 1 | Asynchronous active-low interrupt pin |
| vec_ack | input | 1 | One-cycle vector-fetch acknowledge from the CPU |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| cpu_irq_req | output | 1 | Request to the CPU, gated by the mask |

## Verification
Each result has a fixed due cycle:

- A pin change shows at the outputs on the third rising edge after it is driven: two synchronizer edges plus the latch edge.
- Register writes, acknowledges and reset take effect on the single edge that samples them.

The driver tasks record each expected value with the exact cycle in which it is due. The monitor compares it at the falling edge of that cycle, so a result that arrives one cycle early or late counts as a mismatch. The tie case is built by timing the acknowledge to land on the same edge as the detected fall.

// File: rtl/ext_irq_pkg.sv
// Package: shared register layout and widths for the external interrupt latch.
// Assumes an 8-bit register port; bit positions are decoded by software.
package ext_irq_pkg;
    localparam int REG_W    = 8;
    localparam int BIT_MODE = 0;   // 1 = edge plus low level
    localparam int BIT_MASK = 1;   // 1 = request held off the CPU
    localparam int BIT_ACK  = 2;   // write-only acknowledge
    localparam int BIT_STAT = 3;   // read-only pending status
endpackage

// File: rtl/irq_pin_sync.sv
// Brings the asynchronous pin into the clock domain and flags falling edges.
// Assumes: the chain has no reset and tracks the pin during reset, so a reset
// lasting at least SYNC_STAGES+1 cycles leaves no false edge at release.
module irq_pin_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic pin_n,
    output logic pin_sync,   // synchronized level
    output logic pin_prev,   // synchronized level one cycle older
    output logic pin_fall    // high for one cycle after a 1->0 transition
);
    logic [SYNC_STAGES-1:0] chain_q;
    logic                   prev_q;

    // Shift the pin through the synchronizer stages.
    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) chain_q <= pin_n;
        end else begin : g_many
            always_ff @(posedge clk) chain_q <= {chain_q[SYNC_STAGES-2:0], pin_n};
        end
    endgenerate

    // Keep the previous synchronized sample for edge comparison.
    always_ff @(posedge clk) prev_q <= chain_q[SYNC_STAGES-1];

    assign pin_sync = chain_q[SYNC_STAGES-1];
    assign pin_prev = prev_q;
    assign pin_fall = prev_q & ~chain_q[SYNC_STAGES-1];
endmodule

// File: rtl/irq_ctl_reg.sv
// Control/status register: mode and mask storage, acknowledge pulse, readback.
// Assumes one write per cycle; the acknowledge bit is never stored.
module irq_ctl_reg
    import ext_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    input  logic             status,
    output logic             mode_bit,
    output logic             mask_bit,
    output logic             sw_ack,
    output logic [REG_W-1:0] rdata
);
    logic mode_q, mask_q;

    // Store the mode and mask bits on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
            mask_q <= 1'b0;
        end else if (wr_en) begin
            mode_q <= wdata[BIT_MODE];
            mask_q <= wdata[BIT_MASK];
        end
    end

    // Build the read word; the acknowledge bit always reads zero.
    always_comb begin
        rdata           = '0;
        rdata[BIT_MODE] = mode_q;
        rdata[BIT_MASK] = mask_q;
        rdata[BIT_STAT] = status;
    end

    assign mode_bit = mode_q;
    assign mask_bit = mask_q;
    assign sw_ack   = wr_en & wdata[BIT_ACK];
endmodule

// File: rtl/irq_pend_ctrl.sv
// Pending latch and request composition.
// A fall sets the latch and an acknowledge clears it; a fall wins a tie.
// In level mode a low synchronized pin also holds the request, so clearing
// needs both the acknowledge and a high pin, in either order.
module irq_pend_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_fall,
    input  logic pin_prev,
    input  logic ack,
    input  logic mode_bit,
    input  logic mask_bit,
    output logic status,
    output logic cpu_req
);
    logic pend_q;

    // Set on a fall, clear on an acknowledge, the fall taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n)        pend_q <= 1'b0;
        else if (pin_fall) pend_q <= 1'b1;
        else if (ack)      pend_q <= 1'b0;
    end

    // Combine the latch with the level term, then gate with the mask.
    assign status  = pend_q | (mode_bit & ~pin_prev);
    assign cpu_req = status & ~mask_bit;
endmodule

// File: rtl/ext_irq_latch.sv
// Top: external interrupt latch with its control/status register.
// Assumes: vec_ack is a single-cycle strobe in the clk domain; rst_n is synchronous.
module ext_irq_latch
    import ext_irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             irq_pin_n,
    input  logic             vec_ack,
    input  logic             reg_wr_en,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             cpu_irq_req
);
    logic pin_sync, pin_prev, pin_fall;
    logic mode_bit, mask_bit, sw_ack, ack_any, pend_status;

    irq_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .pin_n    (irq_pin_n),
        .pin_sync (pin_sync),
        .pin_prev (pin_prev),
        .pin_fall (pin_fall)
    );

    irq_ctl_reg u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr_en),
        .wdata    (reg_wdata),
        .status   (pend_status),
        .mode_bit (mode_bit),
        .mask_bit (mask_bit),
        .sw_ack   (sw_ack),
        .rdata    (reg_rdata)
    );

    // Merge the hardware and software acknowledges into one clear request.
    assign ack_any = vec_ack | sw_ack;

    irq_pend_ctrl u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_fall (pin_fall),
        .pin_prev (pin_prev),
        .ack      (ack_any),
        .mode_bit (mode_bit),
        .mask_bit (mask_bit),
        .status   (pend_status),
        .cpu_req  (cpu_irq_req)
    );
endmodule

// File: rtl/ext_irq_latch_chk.sv
// Checker for ext_irq_latch, attached with bind below.
module ext_irq_latch_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       pin_fall,
    input logic       pin_sync,
    input logic       ack_any,
    input logic       mode_bit,
    input logic       mask_bit,
    input logic       pend_status,
    input logic       reg_wr_en,
    input logic [7:0] reg_wdata,
    input logic       cpu_irq_req
);
    // R1
    fall_sets_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pin_fall |=> pend_status);

    // R2
    edge_ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_bit && ack_any && !pin_fall && !reg_wr_en) |=> !pend_status);

    // R3
    level_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_bit && !pin_sync && !reg_wr_en) |=> pend_status);

    // R7
    mask_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mask_bit |-> !cpu_irq_req);

    // R8
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (!mode_bit && !mask_bit));

    // R9
    write_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> (mode_bit == $past(reg_wdata[0])));
endmodule

bind ext_irq_latch ext_irq_latch_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pin_fall    (pin_fall),
    .pin_sync    (pin_sync),
    .ack_any     (ack_any),
    .mode_bit    (mode_bit),
    .mask_bit    (mask_bit),
    .pend_status (pend_status),
    .reg_wr_en   (reg_wr_en),
    .reg_wdata   (reg_wdata),
    .cpu_irq_req (cpu_irq_req)
);

// File: tb/ext_irq_latch_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue expected results with their due cycle;
// a monitor at each falling clock edge pops and compares them.
module ext_irq_latch_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       irq_pin_n = 1'b1;
    logic       vec_ack = 1'b0;
    logic       reg_wr_en = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       cpu_irq_req;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;

    typedef struct {
        int         due;
        logic       irq;
        logic [7:0] rd;
        string      tag;
    } exp_t;
    exp_t sb_q[$];

    ext_irq_latch u_ext_irq_latch (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_pin_n   (irq_pin_n),
        .vec_ack     (vec_ack),
        .reg_wr_en   (reg_wr_en),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .cpu_irq_req (cpu_irq_req)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compare every item that falls due in this cycle.
    always @(negedge clk) begin
        while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
            exp_t e;
            e = sb_q.pop_front();
            n_chk++;
            if (e.due != cyc || cpu_irq_req !== e.irq || reg_rdata !== e.rd) begin
                n_fail++;
                $display("FAIL %s: irq=%b rd=%h expected irq=%b rd=%h (cycle %0d due %0d)",
                         e.tag, cpu_irq_req, reg_rdata, e.irq, e.rd, cyc, e.due);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic expect_in(input int d, input logic irq, input logic [7:0] rd, input string tag);
        exp_t e;
        e.due = cyc + d; e.irq = irq; e.rd = rd; e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic wr(input logic [7:0] d);
        reg_wr_en = 1'b1; reg_wdata = d;
        tick(1);
        reg_wr_en = 1'b0; reg_wdata = 8'h00;
    endtask

    task automatic vack();
        vec_ack = 1'b1;
        tick(1);
        vec_ack = 1'b0;
    endtask

    // Watchdog: a hung run counts as one failure and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        tick(4);
        rst_n = 1'b1;
        expect_in(0, 0, 8'h00, "R8 reset state"); tick(2);

        // R1: latency and edge set, edge-only mode
        irq_pin_n = 1'b0;
        expect_in(2, 0, 8'h00, "R1 not yet");
        expect_in(3, 1, 8'h08, "R1 set"); tick(3);
        irq_pin_n = 1'b1; tick(4);
        expect_in(0, 1, 8'h08, "R2 latch holds after pin high");
        // R4: software acknowledge, bit 2 reads 0
        wr(8'h04);
        expect_in(0, 0, 8'h00, "R4 software ack clears"); tick(1);

        // R2: vector ack clears at once while pin stays low
        irq_pin_n = 1'b0; tick(3);
        expect_in(0, 1, 8'h08, "R2 pending");
        vack();
        expect_in(0, 0, 8'h00, "R2 vector ack clears");
        expect_in(3, 0, 8'h00, "R2 stays clear with pin low"); tick(3);
        irq_pin_n = 1'b1; tick(3);

        // R9: mode write and readback
        wr(8'h01);
        expect_in(0, 0, 8'h01, "R9 mode readback"); tick(1);
        // R3 order A: ack first, pin high later
        irq_pin_n = 1'b0; tick(3);
        expect_in(0, 1, 8'h09, "R3 level set");
        vack();
        expect_in(0, 1, 8'h09, "R3 held after ack");
        expect_in(2, 1, 8'h09, "R3 held while low"); tick(2);
        irq_pin_n = 1'b1;
        expect_in(3, 0, 8'h01, "R3 clears when high"); tick(3);
        // R3 order B: pin high first, ack later
        irq_pin_n = 1'b0; tick(3);
        irq_pin_n = 1'b1;
        expect_in(4, 1, 8'h09, "R3 latch held after pin high"); tick(4);
        vack();
        expect_in(0, 0, 8'h01, "R3 ack after high clears"); tick(1);

        // R7: mask hides the request, status stays visible
        wr(8'h03);
        irq_pin_n = 1'b0;
        expect_in(3, 0, 8'h0B, "R7 masked"); tick(3);
        wr(8'h01);
        expect_in(0, 1, 8'h09, "R7 unmasked releases"); tick(1);
        irq_pin_n = 1'b1; tick(3);
        wr(8'h04);
        expect_in(0, 0, 8'h00, "R4 ack with mode cleared"); tick(1);

        // R5: fresh edge after an acknowledge
        irq_pin_n = 1'b0; tick(3);
        wr(8'h04);
        irq_pin_n = 1'b1; tick(3);
        expect_in(0, 0, 8'h00, "R5 cleared");
        irq_pin_n = 1'b0;
        expect_in(3, 1, 8'h08, "R5 new edge sets"); tick(3);

        // R6: edge and ack on the same clock edge
        irq_pin_n = 1'b1; tick(3);
        irq_pin_n = 1'b0; tick(2);
        vack();
        expect_in(0, 1, 8'h08, "R6 edge wins tie"); tick(1);
        wr(8'h04);
        expect_in(0, 0, 8'h00, "R6 later ack clears"); tick(1);

        // R8: reset with mode set and pin held low
        irq_pin_n = 1'b1; tick(3);
        wr(8'h03);
        irq_pin_n = 1'b0; tick(3);
        rst_n = 1'b0; tick(4);
        rst_n = 1'b1;
        expect_in(0, 0, 8'h00, "R8 cleared by reset");
        expect_in(5, 0, 8'h00, "R8 no request with pin low"); tick(5);
        irq_pin_n = 1'b1; tick(3);

        tick(2);
        if (sb_q.size() != 0) begin
            n_chk++; n_fail++;
            $display("FAIL scoreboard: %0d items left, expected 0", sb_q.size());
        end
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule